// File: doc/BRIEF.md
# Reset-Gated Serial Memory Access Guard

This block stands between the front end of a serial memory bus and the engine that runs nonvolatile write cycles. It decides, cycle by cycle, whether the bus may talk to the memory and whether a write cycle may begin. The decision depends on three things: the supervisor's reset-active flag, a write-protect pin and the state of any write cycle already in flight. Protocol decoding and the memory array belong to other blocks. The guard sees only start and stop strobes, a write request and the engine's busy flag.

When reset arrives, bus traffic stops at once. An open transaction is cut short with a one-cycle abort strobe, and no new transaction or write cycle can begin. The guard is careful in the other direction too. A write cycle that was granted before reset keeps its full programmed duration, because the duration timer inside the guard counts on regardless of reset. Once reset clears, the bus stays closed until the front end signals a fresh start condition.

Top module: `mem_access_guard`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, bus_accept, xfer_abort and wr_grant are all 0.
- R2: A bus_start pulse in a cycle with sup_reset low opens a transaction. bus_accept is 1 from the next cycle on. A bus_stop pulse closes the transaction, and bus_accept is 0 from the cycle after the stop. When start and stop come in the same cycle, start wins.
- R3: A bus_start pulse in a cycle with sup_reset high is ignored. After reset clears, bus_accept stays 0 until a new bus_start is seen with sup_reset low.
- R4: bus_accept is 0 in every cycle in which sup_reset is 1. This covers reads as well as writes.
- R5: xfer_abort is 1 for exactly one cycle: the first cycle in which sup_reset is high while a transaction is open. The transaction is then closed. If no transaction is open, reset causes no abort.
- R6: wr_grant is 1 in a cycle exactly when all of these hold in that cycle: wr_req is 1, bus_accept is 1, wp_pin is 0, eng_busy is 0, and no write cycle is in progress.
- R7: While wp_pin is 1, wr_grant stays 0 whatever the other inputs do.
- R8: A grant starts a write cycle that lasts WR_CYCLES cycles. In the WR_CYCLES cycles after a grant no new grant is given, and the next one may come in the cycle after that. sup_reset neither shortens nor pauses this window.
- R9: While eng_busy is 1, wr_grant stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the guard itself |
| sup_reset | input | 1 | Supervisor reset-active flag, 1 = system in reset |
| wp_pin | input | 1 | Write protect, 1 = all writes refused |
| bus_start | input | 1 | One-cycle strobe: bus start condition detected |
| bus_stop | input | 1 | One-cycle strobe: bus stop condition detected |
| wr_req | input | 1 | Front end asks to begin a nonvolatile write cycle |
| eng_busy | input | 1 | Write engine reports it is busy |
| xfer_abort | output | 1 | One-cycle pulse: open transaction cut off by reset |
| bus_accept | output | 1 | Bus transaction may proceed to the memory |
| wr_grant | output | 1 | Write cycle may start in this cycle |

## Verification
The hardest case to reach is a reset that lands in the middle of a granted write cycle, followed by a request that would pass every other gate. The stimulus obtains a grant and raises sup_reset while that same transaction is still open, which fires the abort. It then offers a start strobe during reset that must be ignored, drops reset, and opens a new transaction. The first write request on this new transaction falls on the last cycle of the old write window and must be refused. The request one cycle later must be granted, which shows the timer neither stopped nor paused.

// File: rtl/guard_pkg.sv
package guard_pkg;

    typedef struct packed {
        logic open;
    } bus_st_t;

    typedef struct packed {
        logic req;
        logic accept;
        logic protect;
        logic busy;
        logic active;
    } wr_cond_t;

endpackage

// File: rtl/guard_bus_gate.sv
module guard_bus_gate
    import guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sup_reset,
    input  logic bus_start,
    input  logic bus_stop,
    output logic bus_accept,
    output logic xfer_abort
);

    bus_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sup_reset) begin
            st_d.open = 1'b0;
        end else if (bus_start) begin
            st_d.open = 1'b1;
        end else if (bus_stop) begin
            st_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // open clears on the first reset cycle, so this lasts one cycle
    assign xfer_abort = sup_reset & st_q.open;
    assign bus_accept = st_q.open & ~sup_reset;

endmodule

// File: rtl/guard_wr_timer.sv
module guard_wr_timer #(
    parameter int WR_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);

    localparam int CW = $clog2(WR_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES);
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.cnt    = LOAD;
        end else if (st_q.active) begin
            if (st_q.cnt == ONE) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;

endmodule

// File: rtl/guard_wr_gate.sv
module guard_wr_gate
    import guard_pkg::*;
(
    input  wr_cond_t cond,
    output logic     grant
);

    always_comb begin
        grant = cond.req & cond.accept & ~cond.protect & ~cond.busy & ~cond.active;
    end

endmodule

// File: rtl/mem_access_guard.sv
module mem_access_guard
    import guard_pkg::*;
#(
    parameter int WR_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_reset,
    input  logic wp_pin,
    input  logic bus_start,
    input  logic bus_stop,
    input  logic wr_req,
    input  logic eng_busy,
    output logic xfer_abort,
    output logic bus_accept,
    output logic wr_grant
);

    logic     wr_active;
    wr_cond_t cond;

    guard_bus_gate u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .sup_reset  (sup_reset),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .bus_accept (bus_accept),
        .xfer_abort (xfer_abort)
    );

    always_comb begin
        cond.req     = wr_req;
        cond.accept  = bus_accept;
        cond.protect = wp_pin;
        cond.busy    = eng_busy;
        cond.active  = wr_active;
    end

    guard_wr_gate u_gate (
        .cond  (cond),
        .grant (wr_grant)
    );

    guard_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (wr_grant),
        .active (wr_active)
    );

endmodule

// File: rtl/mem_access_guard_chk.sv
module mem_access_guard_chk #(
    parameter int WR_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic sup_reset,
    input logic wp_pin,
    input logic bus_start,
    input logic eng_busy,
    input logic xfer_abort,
    input logic bus_accept,
    input logic wr_grant
);

    localparam int GW = $clog2(WR_CYCLES + 1);
    localparam logic [GW-1:0] GMAX = GW'(WR_CYCLES);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= GMAX;
        end else if (wr_grant) begin
            gap_q <= '0;
        end else if (gap_q != GMAX) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    AST_NO_ACCEPT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        sup_reset |-> !bus_accept); // R4
    AST_ACCEPT_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_accept) |-> $past(bus_start)); // R2
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |=> !xfer_abort); // R5
    AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |=> !bus_accept); // R5
    AST_ABORT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |-> sup_reset); // R5
    AST_NO_GRANT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        sup_reset |-> !wr_grant); // R6
    AST_NO_GRANT_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        wp_pin |-> !wr_grant); // R7
    AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> !wr_grant); // R9
    AST_GRANT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant |-> (gap_q == GMAX)); // R8

endmodule

bind mem_access_guard mem_access_guard_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sup_reset  (sup_reset),
    .wp_pin     (wp_pin),
    .bus_start  (bus_start),
    .eng_busy   (eng_busy),
    .xfer_abort (xfer_abort),
    .bus_accept (bus_accept),
    .wr_grant   (wr_grant)
);

// File: tb/mem_access_guard_tb.sv
module mem_access_guard_tb;

    localparam int CLK_P = 10;
    localparam int WRC   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_reset = 1'b0, wp_pin = 1'b0, bus_start = 1'b0, bus_stop = 1'b0;
    logic wr_req = 1'b0, eng_busy = 1'b0;
    logic xfer_abort, bus_accept, wr_grant;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic  acc;
        logic  abt;
        logic  gnt;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    mem_access_guard #(.WR_CYCLES(WRC)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sup_reset  (sup_reset),
        .wp_pin     (wp_pin),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .wr_req     (wr_req),
        .eng_busy   (eng_busy),
        .xfer_abort (xfer_abort),
        .bus_accept (bus_accept),
        .wr_grant   (wr_grant)
    );

    // driver: one cycle of stimulus plus the outputs expected in that cycle
    task automatic step(input logic rs, input logic wp, input logic bs, input logic be,
                        input logic rq, input logic bz,
                        input logic ea, input logic eab, input logic eg, input string tag);
        exp_t e;
        @(negedge clk);
        sup_reset = rs; wp_pin = wp; bus_start = bs; bus_stop = be;
        wr_req = rq; eng_busy = bz;
        e.acc = ea; e.abt = eab; e.gnt = eg; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: pops and compares a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (bus_accept !== e.acc || xfer_abort !== e.abt || wr_grant !== e.gnt) begin
                    bad++;
                    $display("FAIL %s: accept/abort/grant actual=%b%b%b expected=%b%b%b",
                             e.tag, bus_accept, xfer_abort, wr_grant, e.acc, e.abt, e.gnt);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with an open attempt held off by rst_n
        step(0,0,1,0,1,0, 0,0,0, "R1 in reset");
        step(0,0,0,0,1,0, 0,0,0, "R1 in reset idle");
        @(negedge clk); rst_n = 1'b1;
        step(0,0,0,0,1,0, 0,0,0, "R1 after reset");

        // R2: open, then write grant and window
        step(0,0,1,0,0,0, 0,0,0, "R2 start cycle");
        step(0,0,0,0,0,0, 1,0,0, "R2 open");
        step(0,0,0,0,1,0, 1,0,1, "R6 first grant");
        for (int i = 0; i < WRC; i++)
            step(0,0,0,0,1,0, 1,0,0, "R8 window blocks");
        step(0,0,0,0,1,0, 1,0,1, "R8 window end grant");

        // reset mid write with open transaction
        step(1,0,0,0,0,0, 0,1,0, "R5 abort pulse");
        step(1,0,0,0,1,0, 0,0,0, "R5 abort single");
        step(1,0,1,0,0,0, 0,0,0, "R3 start in reset");
        step(0,0,0,0,1,0, 0,0,0, "R3 no reopen");
        step(0,0,1,0,0,0, 0,0,0, "R2 restart");
        step(0,0,0,0,1,0, 1,0,0, "R8 reset keeps window");
        step(0,0,0,0,1,0, 1,0,1, "R8 window not paused");

        // protect and busy
        for (int i = 0; i < WRC; i++)
            step(0,0,0,0,0,0, 1,0,0, "R2 hold open");
        step(0,1,0,0,1,0, 1,0,0, "R7 protect blocks");
        step(0,0,0,0,1,1, 1,0,0, "R9 busy blocks");
        step(0,1,0,0,1,1, 1,0,0, "R7 protect and busy");
        step(0,0,0,0,1,0, 1,0,1, "R6 clear grant");

        // stop, then reset with nothing open
        step(0,0,0,1,0,0, 1,0,0, "R2 stop cycle");
        step(0,0,0,0,1,0, 0,0,0, "R6 no grant closed");
        step(1,0,0,0,0,0, 0,0,0, "R5 no abort when closed");
        step(0,0,0,0,0,0, 0,0,0, "R3 idle after reset");

        // start and stop together: start wins
        step(0,0,1,1,0,0, 0,0,0, "R2 start+stop");
        step(0,0,0,0,0,0, 1,0,0, "R2 start wins");
        step(0,0,0,1,0,0, 1,0,0, "R2 stop again");
        step(0,0,0,0,0,0, 0,0,0, "R2 closed");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule